// File: doc/BRIEF.md
# Audio FIFO DMA Request Handshake Controller

This block sits between the transmit and receive FIFOs of an audio serial port and an external DMA controller. For each direction it raises a service request when the FIFO can take part in a single-word transfer. The transmit side needs free space, and the receive side needs stored data. Each direction also has its own DMA enable. When the DMA controller answers with an acknowledge, the block issues the FIFO write or read strobe in that same cycle. It then withdraws the request for at least one cycle, so that the next decision uses the updated FIFO level.

The FIFOs report their fill level to the block, which is a count from 0 to `DEPTH`. The block registers four status flags from these levels: empty and full for each side. Software reads these flags. The FIFO storage, the serial shifter and register decoding live elsewhere. Only single-word handshakes are supported.

Top module: `dmahs_ctrl`

## Requirements
- R1: While `rst_n` is low, both requests and both strobes are 0, `tx_empty` and `rx_empty` are 1, and `tx_full` and `rx_full` are 0.
- R2: `tx_req` is 1 in a cycle only if, at the preceding clock edge, `tx_dma_en` was 1 and `tx_fill` was below `DEPTH`. With the enable held and room present, it rises at the next edge.
- R3: `rx_req` is 1 in a cycle only if, at the preceding clock edge, `rx_dma_en` was 1 and `rx_fill` was non-zero. With the enable held and data present, it rises at the next edge.
- R4: `tx_wr` (or `rx_rd`) is 1 in exactly the cycles where the matching request, acknowledge and enable are all 1. It is combinational within that cycle.
- R5: In the cycle after a strobe, the matching request is 0. From the cycle after that, it follows R2 or R3 using the new fill level.
- R6: An acknowledge while the matching enable is 0, or while the matching request is 0, produces no strobe.
- R7: Requests come from flops. A change of enable, fill or acknowledge between clock edges leaves them unchanged until the next edge.
- R8: At each edge, `tx_empty`, `tx_full`, `rx_empty` and `rx_full` are loaded with fill==0 and fill==`DEPTH` for their side.
- R9: Clearing an enable takes the matching request to 0 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_dma_en | input | 1 | Transmit DMA enable |
| rx_dma_en | input | 1 | Receive DMA enable |
| tx_fill | input | $clog2(DEPTH+1) | Transmit FIFO level |
| rx_fill | input | $clog2(DEPTH+1) | Receive FIFO level |
| tx_ack | input | 1 | Transmit DMA acknowledge |
| rx_ack | input | 1 | Receive DMA acknowledge |
| tx_req | output | 1 | Transmit DMA request |
| rx_req | output | 1 | Receive DMA request |
| tx_wr | output | 1 | Transmit FIFO write strobe |
| rx_rd | output | 1 | Receive FIFO read strobe |
| tx_empty | output | 1 | Transmit FIFO empty flag |
| tx_full | output | 1 | Transmit FIFO full flag |
| rx_empty | output | 1 | Receive FIFO empty flag |
| rx_full | output | 1 | Receive FIFO full flag |

## Verification
The hardest case to reach is a FIFO one word from its limit with a transfer in progress. There, an early re-request would overrun the transmit FIFO or underrun the receive FIFO. Hitting the exact level by chance is rare. The stimulus therefore adds a closed-loop phase, where a bench model of each FIFO moves by the strobes the block issues and by random drain or fill from the serial side. Fill levels are biased toward 0, 1, `DEPTH-1` and `DEPTH`, so the boundary is crossed many times. Directed steps also raise acknowledge with an enable cleared, and change inputs between edges.

// File: rtl/dmahs_pkg.sv
package dmahs_pkg;

    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } dir_e;

    typedef struct packed {
        logic req;
    } chan_state_t;

    typedef struct packed {
        logic empty;
        logic full;
    } flags_t;

endpackage

// File: rtl/dmahs_chan.sv
module dmahs_chan
    import dmahs_pkg::*;
#(
    parameter int   DEPTH = 16,
    parameter dir_e DIR   = DIR_TX,
    localparam int  CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [CW-1:0] fill,
    input  logic          ack,
    output logic          req,
    output logic          xfer
);

    chan_state_t st_d, st_q;
    logic        room;

    generate
        if (DIR == DIR_TX) begin : g_tx
            assign room = (fill < CW'(DEPTH));
        end else begin : g_rx
            assign room = (fill != '0);
        end
    endgenerate

    always_comb begin
        st_d     = st_q;
        st_d.req = en && room && !(st_q.req && ack);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req  = st_q.req;
    assign xfer = st_q.req && ack && en;

    assert_req_needs_room_R2_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> $past(en && room));
    assert_gap_after_xfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |=> !req);
    assert_disable_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !req);
    assert_no_xfer_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!en || !req) |-> !xfer);

endmodule

// File: rtl/dmahs_flags.sv
module dmahs_flags
    import dmahs_pkg::*;
#(
    parameter int  DEPTH = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] fill,
    output logic          empty,
    output logic          full
);

    flags_t fl_d, fl_q;
    logic   seen_q;

    always_comb begin
        fl_d       = fl_q;
        fl_d.empty = (fill == '0);
        fl_d.full  = (fill == CW'(DEPTH));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q   <= '{empty: 1'b1, full: 1'b0};
            seen_q <= 1'b0;
        end else begin
            fl_q   <= fl_d;
            seen_q <= 1'b1;
        end
    end

    assign empty = fl_q.empty;
    assign full  = fl_q.full;

    assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));
    assert_empty_tracks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (empty == $past(fill == '0)));
    assert_full_tracks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> (full == $past(fill == CW'(DEPTH))));

endmodule

// File: rtl/dmahs_ctrl.sv
module dmahs_ctrl
    import dmahs_pkg::*;
#(
    parameter int  DEPTH = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_dma_en,
    input  logic          rx_dma_en,
    input  logic [CW-1:0] tx_fill,
    input  logic [CW-1:0] rx_fill,
    input  logic          tx_ack,
    input  logic          rx_ack,
    output logic          tx_req,
    output logic          rx_req,
    output logic          tx_wr,
    output logic          rx_rd,
    output logic          tx_empty,
    output logic          tx_full,
    output logic          rx_empty,
    output logic          rx_full
);

    dmahs_chan #(.DEPTH(DEPTH), .DIR(DIR_TX)) u_tx_chan (
        .clk(clk), .rst_n(rst_n), .en(tx_dma_en), .fill(tx_fill),
        .ack(tx_ack), .req(tx_req), .xfer(tx_wr)
    );

    dmahs_chan #(.DEPTH(DEPTH), .DIR(DIR_RX)) u_rx_chan (
        .clk(clk), .rst_n(rst_n), .en(rx_dma_en), .fill(rx_fill),
        .ack(rx_ack), .req(rx_req), .xfer(rx_rd)
    );

    dmahs_flags #(.DEPTH(DEPTH)) u_tx_flags (
        .clk(clk), .rst_n(rst_n), .fill(tx_fill), .empty(tx_empty), .full(tx_full)
    );

    dmahs_flags #(.DEPTH(DEPTH)) u_rx_flags (
        .clk(clk), .rst_n(rst_n), .fill(rx_fill), .empty(rx_empty), .full(rx_full)
    );

    assert_wr_in_handshake_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr |-> (tx_req && tx_ack));
    assert_rd_in_handshake_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rd |-> (rx_req && rx_ack));
    assert_no_wr_when_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr |-> $past(tx_fill < CW'(DEPTH)));
    assert_no_rd_when_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rd |-> $past(rx_fill != '0));

endmodule

// File: tb/dmahs_ctrl_tb_top.sv
`timescale 1ns/1ps
module dmahs_ctrl_tb_top;

    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_dma_en = 1'b0, rx_dma_en = 1'b0, tx_ack = 1'b0, rx_ack = 1'b0;
    logic [CW-1:0] tx_fill = '0, rx_fill = '0;
    logic tx_req, rx_req, tx_wr, rx_rd, tx_empty, tx_full, rx_empty, rx_full;

    int n_checks = 0;
    int n_fail   = 0;

    // bench model state
    logic m_treq = 0, m_rreq = 0;
    logic m_te = 1, m_tf = 0, m_re = 1, m_rf = 0;
    logic m_tgap = 0, m_rgap = 0, m_toff = 0, m_roff = 0;
    logic last_wr = 0, last_rd = 0;

    always #2.5 clk = ~clk;

    dmahs_ctrl #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .tx_dma_en(tx_dma_en), .rx_dma_en(rx_dma_en),
        .tx_fill(tx_fill), .rx_fill(rx_fill), .tx_ack(tx_ack), .rx_ack(rx_ack),
        .tx_req(tx_req), .rx_req(rx_req), .tx_wr(tx_wr), .rx_rd(rx_rd),
        .tx_empty(tx_empty), .tx_full(tx_full), .rx_empty(rx_empty), .rx_full(rx_full)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FIFO-DMA FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic exp_req(input logic en, input logic room, input logic prev, input logic ack);
        return en && room && !(prev && ack);
    endfunction

    function automatic int pick_level();
        int r = int'($urandom_range(0, 9));
        case (r)
            0: return 0;
            1: return 1;
            2: return DEPTH - 1;
            3: return DEPTH;
            default: return int'($urandom_range(0, DEPTH));
        endcase
    endfunction

    task automatic step(input logic ten, input logic ren, input logic tak, input logic rak,
                        input int tf, input int rf, input logic midchg);
        logic ewr, erd;
        @(negedge clk);
        chk(m_tgap ? "R5" : (m_toff ? "R9" : "R2"), tx_req, m_treq);
        chk(m_rgap ? "R5" : (m_roff ? "R9" : "R3"), rx_req, m_rreq);
        chk("R8", tx_empty, m_te);
        chk("R8", tx_full,  m_tf);
        chk("R8", rx_empty, m_re);
        chk("R8", rx_full,  m_rf);
        tx_dma_en = ten; rx_dma_en = ren; tx_ack = tak; rx_ack = rak;
        tx_fill = CW'(tf); rx_fill = CW'(rf);
        #1;
        ewr = tak && m_treq && ten;
        erd = rak && m_rreq && ren;
        chk((tak && !ewr) ? "R6" : "R4", tx_wr, ewr);
        chk((rak && !erd) ? "R6" : "R4", rx_rd, erd);
        if (midchg) begin
            tx_dma_en = ~ten; rx_dma_en = ~ren;
            tx_fill = CW'(DEPTH - tf); rx_fill = CW'(DEPTH - rf);
            #0.5;
            chk("R7", tx_req, m_treq);
            chk("R7", rx_req, m_rreq);
            tx_dma_en = ten; rx_dma_en = ren; tx_fill = CW'(tf); rx_fill = CW'(rf);
        end
        last_wr = tx_wr; last_rd = rx_rd;
        @(posedge clk);
        m_tgap = m_treq && tak && ten;
        m_rgap = m_rreq && rak && ren;
        m_toff = !ten; m_roff = !ren;
        m_treq = exp_req(ten, tf < DEPTH, m_treq, tak);
        m_rreq = exp_req(ren, rf != 0,    m_rreq, rak);
        m_te = (tf == 0); m_tf = (tf == DEPTH);
        m_re = (rf == 0); m_rf = (rf == DEPTH);
    endtask

    initial begin
        #(200000 * 5);
        n_checks++; n_fail++;
        $display("FIFO-DMA FAIL watchdog: actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int tfl, rfl;
        void'($urandom(32'd4711));
        #7;
        chk("R1", tx_req, 1'b0);   chk("R1", rx_req, 1'b0);
        chk("R1", tx_wr, 1'b0);    chk("R1", rx_rd, 1'b0);
        chk("R1", tx_empty, 1'b1); chk("R1", tx_full, 1'b0);
        chk("R1", rx_empty, 1'b1); chk("R1", rx_full, 1'b0);
        @(negedge clk); rst_n = 1'b1;

        // directed: enable with room, then ack, gap, re-request
        step(1, 1, 0, 0, 5, 5, 0);
        step(1, 1, 0, 0, 5, 5, 0);
        step(1, 1, 1, 1, 5, 5, 0);
        step(1, 1, 0, 0, 6, 4, 0);
        step(1, 1, 0, 0, 6, 4, 0);
        // boundary: full tx / empty rx
        step(1, 1, 0, 0, DEPTH, 0, 0);
        step(1, 1, 1, 1, DEPTH, 0, 0);
        step(1, 1, 0, 0, DEPTH - 1, 1, 0);
        step(1, 1, 1, 1, DEPTH - 1, 1, 0);
        step(1, 1, 0, 0, DEPTH, 0, 0);
        // ack with enables cleared (R6) and disable drop (R9)
        step(1, 1, 0, 0, 3, 3, 0);
        step(0, 0, 1, 1, 3, 3, 0);
        step(0, 0, 1, 1, 3, 3, 0);
        step(1, 1, 0, 0, 3, 3, 0);
        // mid-cycle changes (R7)
        for (int i = 0; i < 20; i++) step(1, 1, 0, 0, 2, 2, 1);

        // random open loop
        for (int i = 0; i < 4000; i++)
            step(logic'($urandom_range(0, 7) != 0), logic'($urandom_range(0, 7) != 0),
                 logic'($urandom_range(0, 1)), logic'($urandom_range(0, 1)),
                 pick_level(), pick_level(), logic'($urandom_range(0, 31) == 0));

        // closed loop around bench FIFO models
        tfl = DEPTH - 2; rfl = 2;
        for (int i = 0; i < 4000; i++) begin
            step(1, 1, logic'($urandom_range(0, 3) != 0), logic'($urandom_range(0, 3) != 0),
                 tfl, rfl, 0);
            tfl = tfl + int'(last_wr);
            rfl = rfl - int'(last_rd);
            chk("R2", logic'(tfl <= DEPTH), 1'b1);
            chk("R3", logic'(rfl >= 0), 1'b1);
            if (tfl > 0 && $urandom_range(0, 3) == 0) tfl--;
            if (rfl < DEPTH && $urandom_range(0, 3) == 0) rfl++;
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule